// File: doc/BRIEF.md
# Conditional Select Execution Unit

This unit takes one 32-bit conditional-select instruction word, splits it into its fields, checks the fixed encoding bits and asks the register file for the two source operands. It then tests a 4-bit condition code against the incoming N, Z, C and V flags. When the condition holds, it returns the first source operand. When the condition fails, it returns a modified copy of the second source operand. The modification is an optional bitwise inversion followed by an optional increment, each turned on by its own encoding bit. This one datapath therefore covers four operations: plain select, select-and-increment, select-and-invert and select-and-negate.

Decode and execute happen in a single combinational stage. A result register captures the output on every clock edge where the input is valid. The width bit chooses between 64-bit operation and 32-bit operation; in 32-bit mode the result is zero-extended. The unit also flags the conditional-set form, whose result can only be 0 or 1. It refuses malformed words through an illegal output, and it suppresses writes to the zero-register index.

Top module: `csel_unit`

## Requirements
- R1: The source indices are presented combinationally: `rn_idx_o` = instr[9:5] and `rm_idx_o` = instr[20:16]. The destination index is instr[4:0].
- R2: When the condition holds, the result is the first source value (Rn).
- R3: When the condition fails, the result is the second source value (Rm). It is bitwise inverted if instr[30] is 1, and then 1 is added if instr[10] is 1, with the inversion applied first. The increment wraps around with no carry output.
- R4: instr[31] = 1 selects 64-bit operation. instr[31] = 0 makes selection, inversion and increment act on the low 32 bits only, and result bits [63:32] are 0.
- R5: A source index of 31 reads as 0, whatever the register-read data input carries.
- R6: The condition is instr[15:12], tested against flags_i = {N,Z,C,V} (bit 3 down to bit 0). The base tests are: 000x Z, 001x C, 010x N, 011x V, 100x C&!Z, 101x N==V, 110x !Z&(N==V). Bit 0 = 1 negates the base test, except that 1110 and 1111 are both always true.
- R7: The word is illegal when instr[29:21] differs from 011010100 or instr[11] is 1. An illegal word gives illegal_o = 1, wr_en_o = 0, is_cset_o = 0 and result_o = 0.
- R8: A destination index of 31 keeps wr_en_o low.
- R9: is_cset_o is 1 exactly when the word is legal, instr[30] = 0, instr[10] = 1, and both source indices are 31.
- R10: The outputs are registered. valid_o equals valid_i from the previous rising edge. On a valid cycle, result_o, rd_idx_o, is_cset_o and illegal_o update one edge later. Without a valid input, wr_en_o is 0 and those four outputs hold their values.
- R11: While rst_ni is low, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are valid |
| instr_i | input | 32 | Instruction word |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| rn_idx_o | output | 5 | Read index for the first source |
| rm_idx_o | output | 5 | Read index for the second source |
| rn_data_i | input | 64 | Register value at rn_idx_o |
| rm_data_i | input | 64 | Register value at rm_idx_o |
| valid_o | output | 1 | Registered outputs hold a new result |
| result_o | output | 64 | Result value |
| wr_en_o | output | 1 | Write the result to rd_idx_o |
| rd_idx_o | output | 5 | Destination index |
| is_cset_o | output | 1 | Word is the conditional-set form |
| illegal_o | output | 1 | Fixed encoding bits do not match |

## Verification
The only state in the unit is its output register. A fault in the condition decoder or in the invert/increment path therefore shows up on result_o exactly one clock after the offending valid word, with no delay or masking. A fault in the hold or enable logic shows up as stale or changed outputs, or as a spurious wr_en_o, on the first idle cycle after a valid one. The reference model checks every output on every clock, including idle cycles. The stimulus covers all sixteen condition codes against several flag patterns, both width modes, wrap-around at all-ones, and the zero-register cases.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [8:0] FIXED_PAT = 9'b011010100;

  typedef struct packed {
    logic              wide;
    logic              inv;
    logic [REG_AW-1:0] rm;
    logic [3:0]        cond;
    logic              inc;
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rd;
    logic              legal;
  } csel_fields_t;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic [31:0]  instr_i,
  output csel_fields_t fld_o,
  output logic         is_cset_o
);
  localparam logic [REG_AW-1:0] ZR = '1;

  always_comb begin
    fld_o.wide  = instr_i[31];
    fld_o.inv   = instr_i[30];
    fld_o.rm    = instr_i[20:16];
    fld_o.cond  = instr_i[15:12];
    fld_o.inc   = instr_i[10];
    fld_o.rn    = instr_i[9:5];
    fld_o.rd    = instr_i[4:0];
    fld_o.legal = (instr_i[29:21] == FIXED_PAT) && !instr_i[11];
  end

  assign is_cset_o = fld_o.legal && !fld_o.inv && fld_o.inc &&
                     (fld_o.rn == ZR) && (fld_o.rm == ZR);
endmodule

// File: rtl/csel_cond.sv
module csel_cond (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       taken_o
);
  logic n, z, c, v, base;
  assign {n, z, c, v} = flags_i;

  always_comb begin
    unique case (cond_i[3:1])
      3'd0:    base = z;
      3'd1:    base = c;
      3'd2:    base = n;
      3'd3:    base = v;
      3'd4:    base = c & ~z;
      3'd5:    base = (n == v);
      3'd6:    base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    // always-true pair ignores the negate bit
    taken_o = (cond_i[3:1] == 3'd7) ? 1'b1 : (base ^ cond_i[0]);
  end

  always_comb begin
    if (cond_i[3:1] == 3'd7) a_r6_always_true: assert (taken_o);
  end
endmodule

// File: rtl/csel_alu.sv
module csel_alu #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned REG_AW = 5
) (
  input  logic              wide_i,
  input  logic              inv_i,
  input  logic              inc_i,
  input  logic              taken_i,
  input  logic [REG_AW-1:0] rn_idx_i,
  input  logic [REG_AW-1:0] rm_idx_i,
  input  logic [XLEN-1:0]   rn_data_i,
  input  logic [XLEN-1:0]   rm_data_i,
  output logic [XLEN-1:0]   res_o
);
  localparam int unsigned     HALF = XLEN / 2;
  localparam logic [REG_AW-1:0] ZR = '1;

  logic [XLEN-1:0] rn_v, rm_v, alt, sel;

  assign rn_v = (rn_idx_i == ZR) ? '0 : rn_data_i;
  assign rm_v = (rm_idx_i == ZR) ? '0 : rm_data_i;
  assign alt  = (inv_i ? ~rm_v : rm_v) + {{(XLEN-1){1'b0}}, inc_i};
  assign sel  = taken_i ? rn_v : alt;
  // narrow mode: low half only, wrap falls out of truncation
  assign res_o = wide_i ? sel : {{(XLEN-HALF){1'b0}}, sel[HALF-1:0]};
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [3:0]        flags_i,
  output logic [REG_AW-1:0] rn_idx_o,
  output logic [REG_AW-1:0] rm_idx_o,
  input  logic [XLEN-1:0]   rn_data_i,
  input  logic [XLEN-1:0]   rm_data_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] rd_idx_o,
  output logic              is_cset_o,
  output logic              illegal_o
);
  localparam logic [REG_AW-1:0] ZR = '1;

  csel_fields_t    fld;
  logic            cset, taken;
  logic [XLEN-1:0] res;

  csel_decode u_dec (.instr_i(instr_i), .fld_o(fld), .is_cset_o(cset));

  csel_cond u_cond (.cond_i(fld.cond), .flags_i(flags_i), .taken_o(taken));

  csel_alu #(.XLEN(XLEN), .REG_AW(REG_AW)) u_alu (
    .wide_i   (fld.wide),
    .inv_i    (fld.inv),
    .inc_i    (fld.inc),
    .taken_i  (taken),
    .rn_idx_i (fld.rn),
    .rm_idx_i (fld.rm),
    .rn_data_i(rn_data_i),
    .rm_data_i(rm_data_i),
    .res_o    (res)
  );

  assign rn_idx_o = fld.rn;
  assign rm_idx_o = fld.rm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      result_o  <= '0;
      rd_idx_o  <= '0;
      is_cset_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && fld.legal && (fld.rd != ZR);
      if (valid_i) begin
        result_o  <= fld.legal ? res : '0;
        rd_idx_o  <= fld.rd;
        is_cset_o <= cset;
        illegal_o <= !fld.legal;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o);
  a_r8_no_zr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rd_idx_o != ZR));
  a_r7_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !is_cset_o && result_o == '0));
  a_r9_cset_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && is_cset_o) |-> (result_o[XLEN-1:1] == '0));
endmodule

// File: tb/csel_unit_test.sv
module csel_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] instr_i;
  logic [3:0]  flags_i;
  logic [4:0]  rn_idx_o, rm_idx_o, rd_idx_o;
  logic [63:0] rn_data_i, rm_data_i, result_o;
  logic        valid_o, wr_en_o, is_cset_o, illegal_o;

  logic [63:0] regs [32];
  int vectors = 0;
  int errors  = 0;

  logic [63:0] e_res;
  logic        e_valid, e_wr, e_cset, e_ill;
  logic [4:0]  e_rd;

  always #10 clk_i = ~clk_i;

  assign rn_data_i = regs[rn_idx_o];
  assign rm_data_i = regs[rm_idx_o];

  csel_unit uut (.*);

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic logic [31:0] mk(logic sf, logic op, logic [4:0] rm, logic [3:0] cond,
                                     logic o2, logic [4:0] rn, logic [4:0] rd);
    return {sf, op, 9'b011010100, rm, cond, 1'b0, o2, rn, rd};
  endfunction

  function automatic bit cond_true(logic [3:0] cc, logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      4'b0000: return z;            4'b0001: return !z;
      4'b0010: return c;            4'b0011: return !c;
      4'b0100: return n;            4'b0101: return !n;
      4'b0110: return v;            4'b0111: return !v;
      4'b1000: return c && !z;      4'b1001: return !(c && !z);
      4'b1010: return n == v;       4'b1011: return n != v;
      4'b1100: return !z && n == v; 4'b1101: return !(!z && n == v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk1(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chkv(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk1("R10 valid_o", valid_o, e_valid);
    chk1("R8/R7/R10 wr_en_o", wr_en_o, e_wr);
    chkv("R2/R3/R4/R5/R6 result_o", result_o, e_res);
    chkv("R10 rd_idx_o", {59'd0, rd_idx_o}, {59'd0, e_rd});
    chk1("R9 is_cset_o", is_cset_o, e_cset);
    chk1("R7 illegal_o", illegal_o, e_ill);
  endtask

  // Reference model: behaviour of one input cycle
  task automatic model(logic v, logic [31:0] w, logic [3:0] f);
    logic [63:0] a, b, r;
    bit legal, narrow;
    e_valid = v;
    legal  = (w[29:21] == 9'b011010100) && (w[11] == 1'b0);
    narrow = !w[31];
    e_wr = v && legal && (w[4:0] != 5'd31);
    if (v) begin
      a = (w[9:5]   == 5'd31) ? 64'd0 : regs[w[9:5]];
      b = (w[20:16] == 5'd31) ? 64'd0 : regs[w[20:16]];
      if (cond_true(w[15:12], f)) r = a;
      else begin
        r = b;
        if (w[30]) r = ~r;
        if (w[10]) r = r + 64'd1;
      end
      if (narrow) r = r & 64'h0000_0000_FFFF_FFFF;
      e_res  = legal ? r : 64'd0;
      e_rd   = w[4:0];
      e_ill  = !legal;
      e_cset = legal && !w[30] && w[10] && w[9:5] == 5'd31 && w[20:16] == 5'd31;
    end
  endtask

  task automatic apply(logic v, logic [31:0] w, logic [3:0] f);
    @(negedge clk_i);
    compare_outputs();
    valid_i = v; instr_i = w; flags_i = f;
    #1;
    chkv("R1 rn_idx_o", {59'd0, rn_idx_o}, {59'd0, w[9:5]});
    chkv("R1 rm_idx_o", {59'd0, rm_idx_o}, {59'd0, w[20:16]});
    model(v, w, f);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
    regs[31] = 64'hDEAD_BEEF_CAFE_F00D;   // must never be seen (R5)
    regs[1]  = 64'hFFFF_FFFF_FFFF_FFFF;
    regs[2]  = 64'h0000_0000_FFFF_FFFF;
    regs[3]  = 64'h1234_5678_9ABC_DEF0;
    regs[4]  = 64'd0;
    rst_ni = 1'b0; valid_i = 1'b0; instr_i = '0; flags_i = '0;
    e_valid = 0; e_wr = 0; e_res = 0; e_rd = 0; e_cset = 0; e_ill = 0;
    repeat (3) @(negedge clk_i);
    compare_outputs();                        // R11 reset state
    rst_ni = 1'b1;

    // R2/R6: every condition against several flag patterns
    for (int cc = 0; cc < 16; cc++)
      for (int fl = 0; fl < 16; fl += 5)
        apply(1, mk(1, 0, 5'd4, cc[3:0], 0, 5'd3, 5'd7), fl[3:0]);
    // R3: four operations on the failing path (NE with Z=1 fails)
    apply(1, mk(1, 0, 5'd3, 4'b0001, 0, 5'd1, 5'd5), 4'b0100);
    apply(1, mk(1, 0, 5'd3, 4'b0001, 1, 5'd1, 5'd5), 4'b0100);
    apply(1, mk(1, 1, 5'd3, 4'b0001, 0, 5'd1, 5'd5), 4'b0100);
    apply(1, mk(1, 1, 5'd3, 4'b0001, 1, 5'd1, 5'd5), 4'b0100);
    // R3/R4: wrap at all-ones in both widths
    apply(1, mk(1, 0, 5'd1, 4'b0001, 1, 5'd3, 5'd5), 4'b0100);
    apply(1, mk(0, 0, 5'd2, 4'b0001, 1, 5'd3, 5'd5), 4'b0100);
    apply(1, mk(0, 1, 5'd4, 4'b0001, 0, 5'd3, 5'd5), 4'b0100);
    apply(1, mk(0, 0, 5'd4, 4'b0000, 0, 5'd3, 5'd5), 4'b0100);
    // R5/R9: conditional-set form, both outcomes; near miss
    apply(1, mk(1, 0, 5'd31, 4'b0000, 1, 5'd31, 5'd6), 4'b0100);
    apply(1, mk(1, 0, 5'd31, 4'b0000, 1, 5'd31, 5'd6), 4'b0000);
    apply(1, mk(0, 1, 5'd31, 4'b0000, 1, 5'd31, 5'd6), 4'b0000);
    apply(1, mk(1, 0, 5'd31, 4'b0000, 1, 5'd30, 5'd6), 4'b0000);
    // R8: destination 31
    apply(1, mk(1, 0, 5'd1, 4'b1110, 0, 5'd3, 5'd31), 4'b0000);
    // R7: broken fixed field, broken zero bit
    apply(1, mk(1, 0, 5'd1, 4'b1110, 0, 5'd3, 5'd2) ^ 32'h0020_0000, 4'b0);
    apply(1, mk(1, 0, 5'd1, 4'b1110, 0, 5'd3, 5'd2) | 32'h0000_0800, 4'b0);
    // R10: idle cycles hold outputs
    apply(1, mk(1, 0, 5'd1, 4'b1110, 0, 5'd3, 5'd9), 4'b0);
    apply(0, mk(0, 1, 5'd2, 4'b0000, 1, 5'd4, 5'd1), 4'b1111);
    apply(0, 32'hFFFF_FFFF, 4'b0);
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = mk($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      if ($urandom_range(7) == 0) w = w ^ (32'd1 << $urandom_range(29, 21));
      if ($urandom_range(15) == 0) w[11] = 1'b1;
      if ($urandom_range(5) == 0) w[9:5] = 5'd31;
      if ($urandom_range(5) == 0) w[20:16] = 5'd31;
      apply($urandom_range(3) != 0, w, 4'($urandom));
    end
    apply(0, 32'd0, 4'd0);
    @(negedge clk_i);
    compare_outputs();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule